// File: doc/BRIEF.md
# Virtual Address Region and Permission Checker

This block sits in front of address translation and decides, for every memory access, whether it may proceed and where it lands physically. It takes the virtual address, the kind of access (load, store or instruction fetch), the current privilege level, a switch saying whether translation hardware is enabled, and the outcome of an external translation lookup. The lookup outcome is a hit flag, a physical page number and three permission bits. The lookup storage and any table walk live outside the block.

The address map is split at fixed points. The top quarter is a privileged window that skips translation. The whole upper half is closed to unprivileged code. Everything else goes through the lookup result. The allow decision and the physical address are combinational. Every fault is captured in registers one clock later: a one-cycle fault pulse, a fault code, the bad address, and, for translation faults only, the faulting page number and a data-access detail bit. These registers hold until the next fault.

Top module: `addr_chk_top`

## Requirements
- R1: When `mmu_en_i` is 0, every request is allowed and `paddr_o` equals `vaddr_i`, whatever the privilege level or lookup result.
- R2: With translation enabled and privileged mode (`user_mode_i`=0), addresses at or above 0xC0000000 are allowed with `paddr_o` = `vaddr_i`, ignoring the lookup hit and permission inputs.
- R3: With translation enabled and user mode, addresses at or above 0x80000000 are refused with fault code 1 for a fetch and 2 for a load or store. `bad_addr_o` records the address, while `fault_vpn_o` and `data_detail_o` keep their previous values.
- R4: On a lookup hit with the matching permission set (read for loads, write for stores, execute for fetches), the request is allowed and `paddr_o` = {`tlb_ppn_i`, `vaddr_i`[11:0]}. Access type encoding: 0 load, 1 store, 2 fetch, 3 treated as load.
- R5: On a hit without the matching permission, the request is refused with fault code 5 for a load, 6 for a store and 7 for a fetch.
- R6: On a lookup miss, the request is refused with fault code 3 for a fetch and 4 for a load or store.
- R7: On a translation fault (codes 3 to 7), `fault_vpn_o` becomes `vaddr_i`[31:12], `bad_addr_o` becomes `vaddr_i`, and `data_detail_o` becomes 1 unless the access was a fetch.
- R8: `fault_valid_o` is 1 in exactly the cycle after a refused request. `fault_code_o` holds the last fault's code (0 means none yet) until the next fault. All registered outputs are 0 after reset.
- R9: While `req_valid_i` is 0, `allow_o` is 0 and no fault register changes, even if the other inputs describe a faulting access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| vaddr_i | input | 32 | Virtual address |
| acc_type_i | input | 2 | 0 load, 1 store, 2 fetch |
| user_mode_i | input | 1 | 1 = unprivileged |
| mmu_en_i | input | 1 | Translation enabled |
| tlb_hit_i | input | 1 | Lookup hit |
| tlb_ppn_i | input | 20 | Physical page number from lookup |
| tlb_rd_i | input | 1 | Read permitted |
| tlb_wr_i | input | 1 | Write permitted |
| tlb_ex_i | input | 1 | Execute permitted |
| allow_o | output | 1 | Access allowed (combinational) |
| paddr_o | output | 32 | Physical address (combinational) |
| fault_valid_o | output | 1 | Fault pulse, one cycle after the request |
| fault_code_o | output | 3 | Last fault code |
| bad_addr_o | output | 32 | Last faulting address |
| fault_vpn_o | output | 20 | Page number of last translation fault |
| data_detail_o | output | 1 | Last translation fault was not a fetch |

## Verification
`allow_o` and `paddr_o` settle in the same cycle as the request. The bench drives each request on a falling edge and checks these two outputs 1 ns later, before any rising edge. The fault pulse, code, bad address, page number and detail bit change on the next rising edge. The bench checks them on the following falling edge, after the request has been withdrawn, and compares them against a model of the held fault state that it updates only when it expects a fault.

// File: rtl/addr_chk_pkg.sv
package addr_chk_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_SUP_X  = 3'd1,
    FLT_SUP_D  = 3'd2,
    FLT_MISS_X = 3'd3,
    FLT_MISS_D = 3'd4,
    FLT_PERM_R = 3'd5,
    FLT_PERM_W = 3'd6,
    FLT_PERM_X = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    RT_IDENT  = 2'd0,
    RT_XLATE  = 2'd1,
    RT_SUPFLT = 2'd2
  } route_e;

  function automatic logic is_xlate_fault(fault_e f);
    return (f == FLT_MISS_X) || (f == FLT_MISS_D) || (f == FLT_PERM_R) ||
           (f == FLT_PERM_W) || (f == FLT_PERM_X);
  endfunction

endpackage

// File: rtl/addr_region_dec.sv
module addr_region_dec
  import addr_chk_pkg::*;
#(
  parameter int unsigned VA_W = 32,
  parameter logic [VA_W-1:0] BYPASS_BASE = 32'hC000_0000,
  parameter logic [VA_W-1:0] USER_TOP    = 32'h8000_0000
) (
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            user_mode_i,
  input  logic            mmu_en_i,
  output route_e          route_o
);

  logic in_bypass;
  logic in_priv;

  assign in_bypass = (vaddr_i >= BYPASS_BASE);
  assign in_priv   = (vaddr_i >= USER_TOP);

  always_comb begin
    if (!mmu_en_i) begin
      route_o = RT_IDENT;
    end else if (user_mode_i) begin
      route_o = in_priv ? RT_SUPFLT : RT_XLATE;
    end else begin
      route_o = in_bypass ? RT_IDENT : RT_XLATE;
    end
  end

endmodule

// File: rtl/addr_perm_eval.sv
module addr_perm_eval
  import addr_chk_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned PPN_W    = VA_W - PAGE_BITS
) (
  input  route_e             route_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [1:0]         acc_type_i,
  input  logic               tlb_hit_i,
  input  logic [PPN_W-1:0]   tlb_ppn_i,
  input  logic               tlb_rd_i,
  input  logic               tlb_wr_i,
  input  logic               tlb_ex_i,
  output logic               ok_o,
  output logic [VA_W-1:0]    paddr_o,
  output fault_e             fault_o
);

  acc_e acc;
  logic is_fetch;
  logic is_store;
  logic perm_ok;

  assign acc      = acc_e'(acc_type_i);
  assign is_fetch = (acc == ACC_FETCH);
  assign is_store = (acc == ACC_STORE);

  always_comb begin
    unique case (acc)
      ACC_STORE: perm_ok = tlb_wr_i;
      ACC_FETCH: perm_ok = tlb_ex_i;
      default:   perm_ok = tlb_rd_i;
    endcase
  end

  always_comb begin
    ok_o    = 1'b0;
    paddr_o = vaddr_i;
    fault_o = FLT_NONE;
    unique case (route_i)
      RT_IDENT: ok_o = 1'b1;
      RT_SUPFLT: fault_o = is_fetch ? FLT_SUP_X : FLT_SUP_D;
      RT_XLATE: begin
        paddr_o = {tlb_ppn_i, vaddr_i[PAGE_BITS-1:0]};
        if (!tlb_hit_i) begin
          fault_o = is_fetch ? FLT_MISS_X : FLT_MISS_D;
        end else if (!perm_ok) begin
          fault_o = is_fetch ? FLT_PERM_X : (is_store ? FLT_PERM_W : FLT_PERM_R);
        end else begin
          ok_o = 1'b1;
        end
      end
      default: fault_o = FLT_NONE;
    endcase
  end

endmodule

// File: rtl/addr_fault_regs.sv
module addr_fault_regs
  import addr_chk_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  fault_e           fault_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       acc_type_i,
  output logic             fault_valid_o,
  output logic [2:0]       fault_code_o,
  output logic [VA_W-1:0]  bad_addr_o,
  output logic [VPN_W-1:0] fault_vpn_o,
  output logic             data_detail_o
);

  logic take;
  logic xlat;

  assign take = req_valid_i && (fault_i != FLT_NONE);
  assign xlat = is_xlate_fault(fault_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_valid_o <= 1'b0;
      fault_code_o  <= '0;
      bad_addr_o    <= '0;
      fault_vpn_o   <= '0;
      data_detail_o <= 1'b0;
    end else begin
      fault_valid_o <= take;
      if (take) begin
        fault_code_o <= fault_i;
        bad_addr_o   <= vaddr_i;
        if (xlat) begin
          fault_vpn_o   <= vaddr_i[VA_W-1:PAGE_BITS];
          data_detail_o <= (acc_e'(acc_type_i) != ACC_FETCH);
        end
      end
    end
  end

endmodule

// File: rtl/addr_chk_top.sv
module addr_chk_top
  import addr_chk_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [VA_W-1:0] BYPASS_BASE = 32'hC000_0000,
  parameter logic [VA_W-1:0] USER_TOP    = 32'h8000_0000,
  localparam int unsigned PPN_W    = VA_W - PAGE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       acc_type_i,
  input  logic             user_mode_i,
  input  logic             mmu_en_i,
  input  logic             tlb_hit_i,
  input  logic [PPN_W-1:0] tlb_ppn_i,
  input  logic             tlb_rd_i,
  input  logic             tlb_wr_i,
  input  logic             tlb_ex_i,
  output logic             allow_o,
  output logic [VA_W-1:0]  paddr_o,
  output logic             fault_valid_o,
  output logic [2:0]       fault_code_o,
  output logic [VA_W-1:0]  bad_addr_o,
  output logic [PPN_W-1:0] fault_vpn_o,
  output logic             data_detail_o
);

  route_e route;
  logic   ok;
  fault_e fault;

  addr_region_dec #(
    .VA_W(VA_W), .BYPASS_BASE(BYPASS_BASE), .USER_TOP(USER_TOP)
  ) u_dec (
    .vaddr_i     (vaddr_i),
    .user_mode_i (user_mode_i),
    .mmu_en_i    (mmu_en_i),
    .route_o     (route)
  );

  addr_perm_eval #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_perm (
    .route_i    (route),
    .vaddr_i    (vaddr_i),
    .acc_type_i (acc_type_i),
    .tlb_hit_i  (tlb_hit_i),
    .tlb_ppn_i  (tlb_ppn_i),
    .tlb_rd_i   (tlb_rd_i),
    .tlb_wr_i   (tlb_wr_i),
    .tlb_ex_i   (tlb_ex_i),
    .ok_o       (ok),
    .paddr_o    (paddr_o),
    .fault_o    (fault)
  );

  assign allow_o = req_valid_i && ok;

  addr_fault_regs #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .fault_i       (fault),
    .vaddr_i       (vaddr_i),
    .acc_type_i    (acc_type_i),
    .fault_valid_o (fault_valid_o),
    .fault_code_o  (fault_code_o),
    .bad_addr_o    (bad_addr_o),
    .fault_vpn_o   (fault_vpn_o),
    .data_detail_o (data_detail_o)
  );

endmodule

// File: rtl/addr_chk_sva.sv
module addr_chk_sva #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [VA_W-1:0] BYPASS_BASE = 32'hC000_0000,
  localparam int unsigned PPN_W    = VA_W - PAGE_BITS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic [1:0]       acc_type_i,
  input logic             user_mode_i,
  input logic             mmu_en_i,
  input logic             allow_o,
  input logic [VA_W-1:0]  paddr_o,
  input logic             fault_valid_o,
  input logic [2:0]       fault_code_o,
  input logic [VA_W-1:0]  bad_addr_o,
  input logic [PPN_W-1:0] fault_vpn_o,
  input logic             data_detail_o
);

  assert_identity_nommu_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mmu_en_i) |-> (allow_o && paddr_o == vaddr_i));

  assert_bypass_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mmu_en_i && !user_mode_i && vaddr_i >= BYPASS_BASE)
      |-> (allow_o && paddr_o == vaddr_i));

  assert_supfault_keeps_vpn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_o && (fault_code_o == 3'd1 || fault_code_o == 3'd2))
      |-> ($stable(fault_vpn_o) && $stable(data_detail_o)));

  assert_fetch_miss_detail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_o && fault_code_o == 3'd3) |-> !data_detail_o);

  assert_vpn_matches_bad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_o && fault_code_o >= 3'd3)
      |-> (fault_vpn_o == bad_addr_o[VA_W-1:PAGE_BITS]));

  assert_pulse_follows_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> $past(req_valid_i));

  assert_idle_no_allow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !allow_o);

  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(bad_addr_o) && $stable(fault_code_o) && !fault_valid_o));

endmodule

bind addr_chk_top addr_chk_sva #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .BYPASS_BASE(BYPASS_BASE)
) u_sva (.*);

// File: tb/addr_chk_top_test.sv
`timescale 1ns/1ps
module addr_chk_top_test;

  typedef struct packed {
    logic        mmu;
    logic        usr;
    logic [1:0]  acc;
    logic [31:0] va;
    logic        hit;
    logic [19:0] ppn;
    logic [2:0]  rwx;
    logic        allow;
    logic [31:0] pa;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R1 no translation
    '{1'b0, 1'b1, 2'd0, 32'hDEAD_B123, 1'b0, 20'h0,     3'b000, 1'b1, 32'hDEAD_B123, 3'd0},
    // R2 privileged bypass, lookup ignored
    '{1'b1, 1'b0, 2'd0, 32'hC000_1234, 1'b0, 20'h0,     3'b000, 1'b1, 32'hC000_1234, 3'd0},
    '{1'b1, 1'b0, 2'd2, 32'hFFFF_F000, 1'b1, 20'h00001, 3'b000, 1'b1, 32'hFFFF_F000, 3'd0},
    // R4 hits
    '{1'b1, 1'b1, 2'd0, 32'h0001_2345, 1'b1, 20'hABCDE, 3'b100, 1'b1, 32'hABCD_E345, 3'd0},
    '{1'b1, 1'b0, 2'd1, 32'h8000_3FFC, 1'b1, 20'h00042, 3'b010, 1'b1, 32'h0004_2FFC, 3'd0},
    // R5 permission faults
    '{1'b1, 1'b1, 2'd2, 32'h0040_0008, 1'b1, 20'h11111, 3'b110, 1'b0, 32'h0, 3'd7},
    '{1'b1, 1'b1, 2'd1, 32'h1000_0000, 1'b1, 20'h22222, 3'b101, 1'b0, 32'h0, 3'd6},
    '{1'b1, 1'b1, 2'd0, 32'h7FFF_FFFF, 1'b1, 20'h33333, 3'b011, 1'b0, 32'h0, 3'd5},
    // R6 misses
    '{1'b1, 1'b0, 2'd0, 32'hBFFF_F004, 1'b0, 20'h0,     3'b111, 1'b0, 32'h0, 3'd4},
    '{1'b1, 1'b1, 2'd2, 32'h0000_2000, 1'b0, 20'h0,     3'b111, 1'b0, 32'h0, 3'd3},
    // R4 hit at top of user range, R8 code held
    '{1'b1, 1'b1, 2'd0, 32'h7FFF_F000, 1'b1, 20'h55555, 3'b100, 1'b1, 32'h5555_5000, 3'd0},
    // R3 supervisor-only faults
    '{1'b1, 1'b1, 2'd2, 32'h8000_0010, 1'b1, 20'h0,     3'b111, 1'b0, 32'h0, 3'd1},
    '{1'b1, 1'b1, 2'd1, 32'hC000_0020, 1'b1, 20'h0,     3'b111, 1'b0, 32'h0, 3'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic        user_mode_i = 1'b0;
  logic        mmu_en_i = 1'b0;
  logic        tlb_hit_i = 1'b0;
  logic [19:0] tlb_ppn_i = '0;
  logic        tlb_rd_i = 1'b0, tlb_wr_i = 1'b0, tlb_ex_i = 1'b0;
  logic        allow_o;
  logic [31:0] paddr_o;
  logic        fault_valid_o;
  logic [2:0]  fault_code_o;
  logic [31:0] bad_addr_o;
  logic [19:0] fault_vpn_o;
  logic        data_detail_o;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  logic [2:0]  m_code = '0;
  logic [31:0] m_bad = '0;
  logic [19:0] m_vpn = '0;
  logic        m_det = 1'b0;

  always #5 clk_i = ~clk_i;

  addr_chk_top uut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req, input logic pulse);
    check(req, "fault_valid", {31'd0, fault_valid_o}, {31'd0, pulse});
    check(req, "fault_code", {29'd0, fault_code_o}, {29'd0, m_code});
    check(req, "bad_addr", bad_addr_o, m_bad);
    check(req, "fault_vpn", {12'd0, fault_vpn_o}, {12'd0, m_vpn});
    check(req, "data_detail", {31'd0, data_detail_o}, {31'd0, m_det});
  endtask

  task automatic apply(input vec_t v, input logic valid);
    @(negedge clk_i);
    req_valid_i = valid;
    mmu_en_i    = v.mmu;
    user_mode_i = v.usr;
    acc_type_i  = v.acc;
    vaddr_i     = v.va;
    tlb_hit_i   = v.hit;
    tlb_ppn_i   = v.ppn;
    {tlb_rd_i, tlb_wr_i, tlb_ex_i} = v.rwx;
  endtask

  task automatic model_fault(input vec_t v);
    m_code = v.code;
    m_bad  = v.va;
    if (v.code >= 3'd3) begin
      m_vpn = v.va[31:12];
      m_det = (v.acc != 2'd2);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c, input logic mmu, input logic bypass);
    if (!mmu) return "R1";
    if (c == 3'd0) return bypass ? "R2" : "R4";
    if (c <= 3'd2) return "R3";
    if (c <= 3'd4) return "R6";
    return "R5";
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vec_t idle;
    idle = '0;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    check_regs("R8", 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      t = tag_of(VECS[i].code, VECS[i].mmu, !VECS[i].usr && VECS[i].va >= 32'hC000_0000);
      apply(VECS[i], 1'b1);
      #1;
      check(t, "allow", {31'd0, allow_o}, {31'd0, VECS[i].allow});
      if (VECS[i].allow) check(t, "paddr", paddr_o, VECS[i].pa);
      if (VECS[i].code != 3'd0) model_fault(VECS[i]);
      apply(idle, 1'b0);
      #1;
      // R7 translation-fault capture, R3 page/detail unchanged, R8 pulse and hold
      check_regs(VECS[i].code >= 3'd3 ? "R7" : (VECS[i].code != 3'd0 ? "R3" : "R8"),
                 VECS[i].code != 3'd0);
    end

    // R9: faulting inputs with no request leave state alone
    begin
      vec_t v;
      v = '{1'b1, 1'b1, 2'd1, 32'h0123_4567, 1'b0, 20'h0, 3'b000, 1'b0, 32'h0, 3'd4};
      apply(v, 1'b0);
      #1;
      check("R9", "allow_idle", {31'd0, allow_o}, 32'd0);
      @(negedge clk_i);
      #1;
      check_regs("R9", 1'b0);
    end

    // R1: mode and lookup ignored without translation, user high address
    begin
      vec_t v;
      v = '{1'b0, 1'b1, 2'd2, 32'hF000_0ABC, 1'b0, 20'h0, 3'b000, 1'b1, 32'hF000_0ABC, 3'd0};
      apply(v, 1'b1);
      #1;
      check("R1", "allow_user_hi", {31'd0, allow_o}, 32'd1);
      check("R1", "paddr_user_hi", paddr_o, 32'hF000_0ABC);
      apply(idle, 1'b0);
      #1;
      check_regs("R1", 1'b0);
    end

    // R4: access type 3 treated as load
    begin
      vec_t v;
      v = '{1'b1, 1'b1, 2'd3, 32'h0000_5ABC, 1'b1, 20'h0F0F0, 3'b100, 1'b1, 32'h0F0F_0ABC, 3'd0};
      apply(v, 1'b1);
      #1;
      check("R4", "allow_acc3", {31'd0, allow_o}, 32'd1);
      check("R4", "paddr_acc3", paddr_o, 32'h0F0F_0ABC);
      apply(idle, 1'b0);
    end

    // R8: back-to-back faults give a pulse on each
    begin
      vec_t a, b;
      a = '{1'b1, 1'b1, 2'd0, 32'h0000_A000, 1'b0, 20'h0, 3'b000, 1'b0, 32'h0, 3'd4};
      b = '{1'b1, 1'b1, 2'd2, 32'h0000_B000, 1'b0, 20'h0, 3'b000, 1'b0, 32'h0, 3'd3};
      apply(a, 1'b1);
      model_fault(a);
      apply(b, 1'b1);
      #1;
      check_regs("R8", 1'b1);
      model_fault(b);
      apply(idle, 1'b0);
      #1;
      check_regs("R8", 1'b1);
      @(negedge clk_i);
      #1;
      check_regs("R8", 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule